// File: doc/BRIEF.md
# Capture Compare PWM Unit

This unit sits beside two external timers and gives a small processor one pin of timing work. It has three uses. In capture use it records the value of a free-running 16-bit timer when a chosen edge arrives on an input pin. In compare use it watches that timer and acts when the timer equals a stored value. In pulse-width use it produces a waveform with 10-bit duty resolution. The period for that waveform comes from an 8-bit period timer together with its 2-bit prescale count. One 16-bit data register holds the captured value, the compare value or the duty word, depending on the mode.

Software reaches the unit through a byte-wide register port. The low data byte is at address 0 and the high data byte is at address 1. The control byte is at address 2 and holds a 4-bit mode code and two duty extension bits. The event flag is at address 3. Both timers are inputs. The unit drives a timer-reset request only when the special-event compare action fires.

Top module: `ccp_unit`

## Requirements
- R1: After reset, all four addresses read 0x00, `out_pin_o` is low, `flag_o` is low and `tmr_rst_o` is low.
- R2: Address 0 is the low data byte, address 1 is the high data byte and address 2 is the control byte. The control byte is laid out as bits 5:4 duty extension and bits 3:0 mode, and bits 7:6 always read 0. Address 3 shows the flag in bit 0. Any write to address 3 clears the flag unless an event sets it in that same cycle.
- R3: Mode codes 0000 to 0011 switch the unit off. In these modes the output pin is low, pin edges capture nothing and the flag is not set.
- R4: `cap_pin_i` passes through two synchroniser flops. In mode 0101 (rising edges) and in mode 0100 (falling edges), the data register loads `tmr_wide_i` at the third rising clock edge after the pin changes, and the flag is set. An edge of the other polarity captures nothing.
- R5: Mode 0110 captures on every 4th rising edge of the pin. Mode 0111 captures on every 16th rising edge.
- R6: Writing a mode code that differs from the current one clears the edge prescale count.
- R7: Writing mode 1000 drives the pin low. On a match (`tmr_wide_i` equals the data register) the pin goes high at the next clock edge and the flag is set.
- R8: Writing mode 1001 drives the pin high. On a match the pin goes low and the flag is set.
- R9: In mode 1010 a match sets only the flag. The pin keeps its level.
- R10: In mode 1011, `tmr_rst_o` is high in every cycle in which the timer matches the data register, with no register delay. The flag is set and the pin keeps its level.
- R11: Mode codes 11xx select PWM. For each clock, form the count {period timer, prescale} and let D be the active duty {data low byte, duty extension}. The output after that clock edge is high if the count is less than D and low otherwise. A duty of 0 gives a constant low output. A duty at or above the period gives a constant high output.
- R12: A duty that is written takes effect only at the next `per_wrap_i` pulse. The current period finishes with the old duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 2 | Register address |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `sel_i`, combinational |
| tmr_wide_i | input | 16 | Free-running 16-bit timer |
| tmr_rst_o | output | 1 | Request to reset the 16-bit timer |
| per_cnt_i | input | 8 | Period timer value |
| per_pre_i | input | 2 | Period timer prescale count |
| per_wrap_i | input | 1 | Period boundary pulse |
| cap_pin_i | input | 1 | Capture input pin, asynchronous |
| out_pin_o | output | 1 | Compare or PWM output pin |
| flag_o | output | 1 | Event flag |

## Verification
A wrong prescale count shows up at the ports as a capture on the wrong pulse: the flag rises and the data bytes change one or more input pulses early or late. A synchroniser stage that is missing or added moves the capture by one clock, so the data bytes are read both two and three clocks after the pin changes. A wrong latched duty or a wrong compare level shows on `out_pin_o` within one clock of the count that should flip it. The bench therefore compares every cycle of whole PWM periods across a sweep of duties, and that sweep includes writes made in the middle of a period.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  localparam logic [3:0] M_OFF      = 4'b0000;
  localparam logic [3:0] M_CAP_FALL = 4'b0100;
  localparam logic [3:0] M_CAP_RISE = 4'b0101;
  localparam logic [3:0] M_CAP_DA   = 4'b0110;
  localparam logic [3:0] M_CAP_DB   = 4'b0111;
  localparam logic [3:0] M_CMP_SET  = 4'b1000;
  localparam logic [3:0] M_CMP_CLR  = 4'b1001;
  localparam logic [3:0] M_CMP_FLAG = 4'b1010;
  localparam logic [3:0] M_CMP_EVT  = 4'b1011;

  function automatic logic is_cap(input logic [3:0] m);
    return m[3:2] == 2'b01;
  endfunction

  function automatic logic is_cmp(input logic [3:0] m);
    return m[3:2] == 2'b10;
  endfunction

  function automatic logic is_pwm(input logic [3:0] m);
    return m[3:2] == 2'b11;
  endfunction
endpackage

// File: rtl/ccp_capture.sv
module ccp_capture
  import ccp_pkg::*;
#(
  parameter int DIV_A = 4,
  parameter int DIV_B = 16,
  parameter int SYNC  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] mode_i,
  input  logic       mode_chg_i,
  input  logic       pin_i,
  output logic       evt_o
);
  localparam int CW = $clog2(DIV_B);
  localparam logic [CW-1:0] LAST_A = CW'(DIV_A - 1);
  localparam logic [CW-1:0] LAST_B = CW'(DIV_B - 1);

  logic [SYNC:0]   sh_q;
  logic            rise, fall;
  logic [CW-1:0]   cnt_q, cnt_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC-1:0], pin_i};
  end

  assign rise = sh_q[SYNC-1] & ~sh_q[SYNC];
  assign fall = ~sh_q[SYNC-1] & sh_q[SYNC];

  always_comb begin
    evt_o = 1'b0;
    cnt_d = cnt_q;
    case (mode_i)
      M_CAP_FALL: evt_o = fall;
      M_CAP_RISE: evt_o = rise;
      M_CAP_DA: if (rise) begin
        if (cnt_q == LAST_A) begin
          evt_o = 1'b1;
          cnt_d = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
      M_CAP_DB: if (rise) begin
        if (cnt_q == LAST_B) begin
          evt_o = 1'b1;
          cnt_d = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
      default: cnt_d = '0;
    endcase
    if (mode_chg_i) cnt_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assert_cap_mode_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> is_cap(mode_i));
  assert_cnt_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg_i |=> cnt_q == '0);
endmodule

// File: rtl/ccp_compare.sv
module ccp_compare
  import ccp_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [3:0]    mode_i,
  input  logic          load_i,
  input  logic [3:0]    load_mode_i,
  input  logic [TW-1:0] tmr_i,
  input  logic [TW-1:0] ref_i,
  output logic          pin_o,
  output logic          evt_o,
  output logic          tmr_rst_o
);
  logic match;
  assign match     = is_cmp(mode_i) && (tmr_i == ref_i);
  assign evt_o     = match;
  assign tmr_rst_o = match && (mode_i == M_CMP_EVT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_o <= 1'b0;
    else if (load_i) begin
      case (load_mode_i)
        M_CMP_SET:             pin_o <= 1'b0;
        M_CMP_CLR:             pin_o <= 1'b1;
        M_CMP_FLAG, M_CMP_EVT: pin_o <= pin_o;
        default:               pin_o <= 1'b0;
      endcase
    end else if (!is_cmp(mode_i)) pin_o <= 1'b0;
    else if (match) begin
      if (mode_i == M_CMP_SET)      pin_o <= 1'b1;
      else if (mode_i == M_CMP_CLR) pin_o <= 1'b0;
    end
  end

  assert_cmp_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == M_CMP_SET && tmr_i == ref_i && !load_i) |=> pin_o);
  assert_cmp_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == M_CMP_CLR && tmr_i == ref_i && !load_i) |=> !pin_o);
  assert_cmp_keep_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == M_CMP_FLAG || mode_i == M_CMP_EVT) && !load_i) |=> $stable(pin_o));
endmodule

// File: rtl/ccp_pwm.sv
module ccp_pwm #(
  parameter int DB = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          wrap_i,
  input  logic [DB-1:0] cnt_i,
  input  logic [DB-1:0] duty_i,
  output logic          pwm_o
);
  logic [DB-1:0] duty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_q <= '0;
      pwm_o  <= 1'b0;
    end else if (!en_i) begin
      duty_q <= '0;
      pwm_o  <= 1'b0;
    end else if (wrap_i) begin
      duty_q <= duty_i;
      pwm_o  <= (duty_i != '0);
    end else if (cnt_i == duty_q) begin
      pwm_o  <= 1'b0;
    end
  end

  assert_pwm_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && wrap_i && duty_i == '0) |=> !pwm_o);
  assert_pwm_fall_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !wrap_i && cnt_i == duty_q) |=> !pwm_o);
  assert_pwm_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !wrap_i) |=> $stable(duty_q));
endmodule

// File: rtl/ccp_unit.sv
module ccp_unit
  import ccp_pkg::*;
#(
  parameter int TW    = 16,
  parameter int PW    = 8,
  parameter int PSW   = 2,
  parameter int DIV_A = 4,
  parameter int DIV_B = 16,
  parameter int SYNC  = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    sel_i,
  input  logic          wr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  input  logic [TW-1:0] tmr_wide_i,
  output logic          tmr_rst_o,
  input  logic [PW-1:0] per_cnt_i,
  input  logic [PSW-1:0] per_pre_i,
  input  logic          per_wrap_i,
  input  logic          cap_pin_i,
  output logic          out_pin_o,
  output logic          flag_o
);
  localparam int NB = TW / 8;
  localparam int AW = 2;
  localparam int DB = PW + PSW;
  localparam logic [AW-1:0] CTRL_A = AW'(NB);
  localparam logic [AW-1:0] FLAG_A = AW'(NB + 1);

  logic [TW-1:0] data_q;
  logic [5:0]    ctrl_q;
  logic [3:0]    mode;
  logic          ctrl_wr, mode_chg;
  logic          cap_evt, cmp_evt, cmp_pin, pwm_out;

  assign mode     = ctrl_q[3:0];
  assign ctrl_wr  = wr_i && (sel_i == CTRL_A);
  assign mode_chg = ctrl_wr && (wdata_i[3:0] != mode);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= wdata_i[5:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_q <= '0;
    else if (cap_evt) data_q <= tmr_wide_i;
    else if (wr_i) begin
      for (int i = 0; i < NB; i++)
        if (sel_i == AW'(i)) data_q[i*8 +: 8] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= 1'b0;
    else if (cap_evt || cmp_evt) flag_o <= 1'b1;
    else if (wr_i && sel_i == FLAG_A) flag_o <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NB; i++)
      if (sel_i == AW'(i)) rdata_o = data_q[i*8 +: 8];
    if (sel_i == CTRL_A) rdata_o = {2'b00, ctrl_q};
    if (sel_i == FLAG_A) rdata_o = {7'b0, flag_o};
  end

  ccp_capture #(.DIV_A(DIV_A), .DIV_B(DIV_B), .SYNC(SYNC)) u_cap (
    .clk_i, .rst_ni, .mode_i(mode), .mode_chg_i(mode_chg),
    .pin_i(cap_pin_i), .evt_o(cap_evt)
  );

  ccp_compare #(.TW(TW)) u_cmp (
    .clk_i, .rst_ni, .mode_i(mode), .load_i(ctrl_wr), .load_mode_i(wdata_i[3:0]),
    .tmr_i(tmr_wide_i), .ref_i(data_q), .pin_o(cmp_pin), .evt_o(cmp_evt),
    .tmr_rst_o(tmr_rst_o)
  );

  ccp_pwm #(.DB(DB)) u_pwm (
    .clk_i, .rst_ni, .en_i(is_pwm(mode)), .wrap_i(per_wrap_i),
    .cnt_i({per_cnt_i, per_pre_i}), .duty_i({data_q[PW-1:0], ctrl_q[4 +: PSW]}),
    .pwm_o(pwm_out)
  );

  assign out_pin_o = is_pwm(mode) ? pwm_out : cmp_pin;

  assert_flag_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == FLAG_A && !cap_evt && !cmp_evt) |=> !flag_o);
  assert_evt_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_rst_o |=> flag_o);
  assert_off_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == M_OFF && !ctrl_wr) |=> !out_pin_o);
endmodule

// File: tb/tb_ccp_unit.sv
module tb_ccp_unit;
  localparam int CLK_PERIOD = 10;
  localparam int P = 48;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  sel_i = '0;
  logic        wr_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic [15:0] tmr_wide_i = '0;
  logic        tmr_rst_o;
  logic [7:0]  per_cnt_i = '0;
  logic [1:0]  per_pre_i = '0;
  logic        per_wrap_i = 1'b0;
  logic        cap_pin_i = 1'b0;
  logic        out_pin_o;
  logic        flag_o;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  ccp_unit dut (.*);

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    sel_i = a; wdata_i = d; wr_i = 1'b1;
    tick();
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    sel_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(2'd0, lo);
    rd(2'd1, hi);
    v = {hi, lo};
  endtask

  task automatic pulse();
    cap_pin_i = 1'b1;
    repeat (4) tick();
    cap_pin_i = 1'b0;
    repeat (4) tick();
  endtask

  task automatic set_duty(input int d, input int v);
    wr(2'd0, 8'(d >> 2));
    wr(2'd2, {2'b00, 2'(d & 3), 2'b11, 2'(v)});
  endtask

  task automatic run_period(input int d, input bit en, input int wr_at,
                            input logic [7:0] wval, input string tag);
    for (int k = 0; k < P; k++) begin
      per_cnt_i = 8'(k >> 2);
      per_pre_i = 2'(k & 3);
      per_wrap_i = (k == 0);
      if (k == wr_at) begin sel_i = 2'd0; wdata_i = wval; wr_i = 1'b1; end
      else wr_i = 1'b0;
      tick();
      if (en) chk(tag, 32'(out_pin_o), 32'(k < d));
    end
    per_wrap_i = 1'b0;
    wr_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v;
    int ds[8] = '{0, 1, 2, 5, 17, 47, 48, 200};

    repeat (3) tick();
    rst_ni = 1'b1;
    tick();

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), b);
      chk("R1 read", 32'(b), 32'h0);
    end
    chk("R1 pin", 32'(out_pin_o), 0);
    chk("R1 flag", 32'(flag_o), 0);
    chk("R1 tmr_rst", 32'(tmr_rst_o), 0);

    // R2 register map
    wr(2'd0, 8'hA5);
    wr(2'd1, 8'h3C);
    rd16(v);
    chk("R2 data", 32'(v), 32'h3CA5);
    wr(2'd2, 8'hFF);
    rd(2'd2, b);
    chk("R2 ctrl pad", 32'(b), 32'h3F);
    wr(2'd2, 8'h00);

    // R3 off mode ignores pin
    tmr_wide_i = 16'h7777;
    pulse();
    rd16(v);
    chk("R3 no capture", 32'(v), 32'h3CA5);
    chk("R3 flag", 32'(flag_o), 0);
    chk("R3 pin", 32'(out_pin_o), 0);
    wr(2'd2, 8'h03);
    pulse();
    rd16(v);
    chk("R3 mode3 no capture", 32'(v), 32'h3CA5);

    // R4 rising capture with two-flop sync
    wr(2'd2, 8'h05);
    tmr_wide_i = 16'h1234;
    cap_pin_i = 1'b1;
    tick(); tick();
    rd16(v);
    chk("R4 not yet", 32'(v), 32'h3CA5);
    chk("R4 flag not yet", 32'(flag_o), 0);
    tick();
    rd16(v);
    chk("R4 rise capture", 32'(v), 32'h1234);
    chk("R4 flag", 32'(flag_o), 1);
    wr(2'd3, 8'h00);
    chk("R2 flag cleared", 32'(flag_o), 0);
    tmr_wide_i = 16'h5555;
    cap_pin_i = 1'b0;
    repeat (4) tick();
    rd16(v);
    chk("R4 fall ignored", 32'(v), 32'h1234);
    // falling mode
    wr(2'd2, 8'h04);
    tmr_wide_i = 16'h0BEE;
    cap_pin_i = 1'b1;
    repeat (4) tick();
    rd16(v);
    chk("R4 rise ignored", 32'(v), 32'h1234);
    cap_pin_i = 1'b0;
    tick(); tick();
    rd16(v);
    chk("R4 fall not yet", 32'(v), 32'h1234);
    tick();
    rd16(v);
    chk("R4 fall capture", 32'(v), 32'h0BEE);
    wr(2'd3, 8'h00);

    // R5 divide by 4
    wr(2'd2, 8'h06);
    for (int n = 1; n <= 4; n++) begin
      tmr_wide_i = 16'(16'h0100 + n);
      pulse();
      chk("R5 div4 flag", 32'(flag_o), 32'(n == 4));
    end
    rd16(v);
    chk("R5 div4 value", 32'(v), 32'h0104);
    wr(2'd3, 8'h00);
    // R5 divide by 16
    wr(2'd2, 8'h07);
    for (int n = 1; n <= 16; n++) begin
      tmr_wide_i = 16'(16'h0200 + n);
      pulse();
      if (n == 15) chk("R5 div16 early", 32'(flag_o), 0);
    end
    chk("R5 div16 flag", 32'(flag_o), 1);
    rd16(v);
    chk("R5 div16 value", 32'(v), 32'h0210);
    wr(2'd3, 8'h00);

    // R6 mode change clears prescale
    wr(2'd2, 8'h06);
    tmr_wide_i = 16'h0300;
    pulse(); pulse();
    wr(2'd2, 8'h07);
    pulse(); pulse();
    wr(2'd2, 8'h06);
    pulse(); pulse(); pulse();
    chk("R6 no early capture", 32'(flag_o), 0);
    tmr_wide_i = 16'h0306;
    pulse();
    chk("R6 capture on 4th", 32'(flag_o), 1);
    rd16(v);
    chk("R6 value", 32'(v), 32'h0306);

    // R7 compare set
    wr(2'd2, 8'h00);
    tmr_wide_i = 16'h0000;
    wr(2'd3, 8'h00);
    wr(2'd0, 8'h21);
    wr(2'd1, 8'h43);
    wr(2'd2, 8'h08);
    chk("R7 preload low", 32'(out_pin_o), 0);
    tmr_wide_i = 16'h4320;
    tick();
    chk("R7 no match pin", 32'(out_pin_o), 0);
    chk("R7 no match flag", 32'(flag_o), 0);
    tmr_wide_i = 16'h4321;
    #1;
    chk("R7 no tmr_rst", 32'(tmr_rst_o), 0);
    tick();
    chk("R7 match pin", 32'(out_pin_o), 1);
    chk("R7 match flag", 32'(flag_o), 1);

    // R8 compare clear
    tmr_wide_i = 16'h0000;
    wr(2'd3, 8'h00);
    wr(2'd2, 8'h09);
    chk("R8 preload high", 32'(out_pin_o), 1);
    tmr_wide_i = 16'h4321;
    tick();
    chk("R8 match pin", 32'(out_pin_o), 0);
    chk("R8 match flag", 32'(flag_o), 1);

    // R9 flag only
    tmr_wide_i = 16'h0000;
    wr(2'd3, 8'h00);
    wr(2'd2, 8'h09);
    wr(2'd2, 8'h0A);
    chk("R9 pin kept on load", 32'(out_pin_o), 1);
    tmr_wide_i = 16'h4321;
    tick();
    chk("R9 pin kept", 32'(out_pin_o), 1);
    chk("R9 flag", 32'(flag_o), 1);

    // R10 special event
    tmr_wide_i = 16'h0000;
    wr(2'd3, 8'h00);
    wr(2'd2, 8'h0B);
    chk("R10 idle rst", 32'(tmr_rst_o), 0);
    tmr_wide_i = 16'h4321;
    #1;
    chk("R10 rst on match", 32'(tmr_rst_o), 1);
    tick();
    chk("R10 flag", 32'(flag_o), 1);
    chk("R10 pin kept", 32'(out_pin_o), 1);
    tmr_wide_i = 16'h4322;
    #1;
    chk("R10 rst off", 32'(tmr_rst_o), 0);
    tmr_wide_i = 16'h0000;

    // R11 duty sweep, low mode bits varied
    wr(2'd2, 8'h0C);
    chk("R11 low before wrap", 32'(out_pin_o), 0);
    for (int i = 0; i < 8; i++) begin
      set_duty(ds[i], i % 4);
      run_period(ds[i], 1'b0, -1, 8'h00, "R11");
      run_period(ds[i], 1'b1, -1, 8'h00, "R11");
    end

    // R12 double buffering
    set_duty(40, 0);
    run_period(40, 1'b0, -1, 8'h00, "R12");
    run_period(40, 1'b1, 10, 8'h02, "R12 old duty");
    run_period(8, 1'b1, -1, 8'h00, "R12 new duty");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule